// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is the code prefetch buffer of a small bus interface unit. It holds up to twelve instruction bytes read from memory, one aligned 32-bit word per fetch, and hands them in program order to a downstream decoder through a valid/ready byte port. Refill is hysteretic. Once the queue is full, no new fetch starts until the decoder has drained the queue to a low-water mark of four bytes. After that, fetches continue back to back until there is no room for another whole word.

Prefetches have the lowest priority on the bus. A pending data or I/O cycle holds off the start of a fetch. A locked read-modify-write sequence does the same, so that no last fetch can slip in while code is being modified. Bytes already queued are never updated by such writes, and the decoder receives them unchanged. A flush input is used on a jump. It empties the queue, loads a new fetch address and drops any fetch still outstanding.

A three-state controller sequences the fetches. In state HOLD the queue is above the low-water mark and no fetch starts. In state ARMED a refill has been triggered and is waiting for a free bus. In state FETCH a request is outstanding. The transitions are:

- HOLD→FETCH: occupancy is at or below the mark and the bus is free.
- HOLD→ARMED: occupancy is at or below the mark but the bus is busy.
- ARMED→FETCH: the bus is free and a word fits.
- ARMED→HOLD: a word no longer fits.
- FETCH→ARMED: the fetch returns with a ready pulse.
- Any state→ARMED: flush.

Reset enters HOLD.

Top module: `pfq_top`

## Requirements
- R1: While reset is held and at release, byte_valid and fetch_req are 0 and fetch_addr equals RESET_ADDR (0 by default).
- R2: Bytes leave in fetch-address order. Within a word, bits 7:0 are delivered first and bits 31:24 last. Successive fetch addresses rise by 4.
- R3: byte_valid is high exactly when the queue holds at least one byte. One byte is removed in each cycle where byte_valid and byte_ready are both 1.
- R4: From HOLD, no fetch starts while occupancy exceeds LOW_MARK (4), even if free space exists.
- R5: Once refill has been triggered, fetches continue while occupancy plus 4 is at most DEPTH (12). They stop when that no longer holds.
- R6: A fetch never starts in a cycle where data_pending is 1.
- R7: A fetch never starts in a cycle where bus_locked is 1.
- R8: An outstanding fetch keeps fetch_req high and fetch_addr stable until fetch_rdy is 1. Pending or locked bus cycles do not withdraw it.
- R9: Flush empties the queue, so byte_valid is 0 in the next cycle. It cancels any outstanding fetch, including a fetch_rdy given in the same cycle. The next fetch address is flush_addr with its two low bits cleared.
- R10: A fetch_rdy pulse while no fetch is outstanding is ignored, and the queue never holds more than DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty queue and restart fetching at flush_addr |
| flush_addr | input | AW | New fetch address; low two bits ignored |
| data_pending | input | 1 | Higher-priority data or I/O bus cycle waiting |
| bus_locked | input | 1 | Locked read-modify-write sequence in progress |
| fetch_req | output | 1 | Prefetch request outstanding |
| fetch_addr | output | AW | Word-aligned address of the requested fetch |
| fetch_rdy | input | 1 | Fetch completes; fetch_data is valid |
| fetch_data | input | 8*WORD_BYTES | Fetched word, lowest address in bits 7:0 |
| byte_valid | output | 1 | byte_data holds the next instruction byte |
| byte_data | output | 8 | Next instruction byte |
| byte_ready | input | 1 | Decoder takes the byte this cycle |

## Verification
The bench builds the block with its defaults: a depth of twelve, a four-byte low-water mark and four-byte words. With these values a fill goes 0, 4, 8, 12 and then stops. A drain to four bytes re-arms refill, and the low-water mark plus one word never exceeds the depth. The pointers must also wrap at a depth that is not a power of two, which reaches the modulo step of the storage. The run covers:

- the full-queue stop and the hysteretic restart;
- refill held off by long data-pending and locked windows;
- stray ready pulses;
- flushes that land on the same edge as a completing fetch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FETCH = 2'd2
    } pf_state_e;

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 12,
    parameter int WB    = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [8*WB-1:0] push_word,
    input  logic            pop_ready,
    output logic            out_valid,
    output logic [7:0]      out_byte,
    output logic [CW-1:0]   occ
);

    logic [7:0]    mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] occ_q;
    logic [7:0]    lane [WB];
    logic          pop;

    for (genvar g = 0; g < WB; g++) begin : g_lane
        assign lane[g] = push_word[8*g +: 8];
    end

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return s[PW-1:0];
    endfunction

    assign out_valid = (occ_q != '0);
    assign out_byte  = mem_q[rd_q];
    assign pop       = out_valid && pop_ready && !flush;
    assign occ       = occ_q;

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            for (int i = 0; i < WB; i++) begin
                mem_q[step(wr_q, i)] <= lane[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push) wr_q <= step(wr_q, WB);
            if (pop)  rd_q <= step(rd_q, 1);
            occ_q <= occ_q + (push ? CW'(WB) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    // R10
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (occ_q <= CW'(DEPTH - WB)));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ_q == '0 && !out_valid));

    // R3
    pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pop_ready && !push && !flush) |=> (occ_q == $past(occ_q) - CW'(1)));

endmodule

// File: rtl/pfq_addr.sv
module pfq_addr #(
    parameter int          AW         = 32,
    parameter int          WB         = 4,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int         OFS        = $clog2(WB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          advance,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;

    assign addr = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= {RESET_ADDR[AW-1:OFS], {OFS{1'b0}}};
        end else if (flush) begin
            addr_q <= {flush_addr[AW-1:OFS], {OFS{1'b0}}};
        end else if (advance) begin
            addr_q <= addr_q + AW'(WB);
        end
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !flush) |=> (addr_q == $past(addr_q) + AW'(WB)));

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int WB        = 4,
    parameter int LOW_MARK  = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          data_pending,
    input  logic          bus_locked,
    input  logic          fetch_rdy,
    input  logic [CW-1:0] occ,
    output logic          fetch_req,
    output logic          push
);

    pf_state_e st_q, st_d;
    logic      bus_free, low_hit, room;

    assign bus_free = !data_pending && !bus_locked;
    assign low_hit  = (occ <= CW'(LOW_MARK));
    assign room     = (occ <= CW'(DEPTH - WB));

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = ST_ARMED;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    if (low_hit) st_d = (bus_free && room) ? ST_FETCH : ST_ARMED;
                end
                ST_ARMED: begin
                    if (!room)         st_d = ST_HOLD;
                    else if (bus_free) st_d = ST_FETCH;
                end
                ST_FETCH: begin
                    if (fetch_rdy) st_d = ST_ARMED;
                end
                default: st_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_comb begin
        fetch_req = (st_q == ST_FETCH);
        push      = (st_q == ST_FETCH) && fetch_rdy && !flush;
    end

    // R6
    no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> !$past(data_pending));

    // R7
    no_start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> !$past(bus_locked));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_rdy && !flush) |=> fetch_req);

    // R4
    hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && !low_hit && !flush) |=> (st_q != ST_FETCH));

    // R9
    flush_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fetch_req);

endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int            AW         = 32,
    parameter int            DEPTH      = 12,
    parameter int            WORD_BYTES = 4,
    parameter int            LOW_MARK   = 4,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           CW         = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [AW-1:0]           flush_addr,
    input  logic                    data_pending,
    input  logic                    bus_locked,
    output logic                    fetch_req,
    output logic [AW-1:0]           fetch_addr,
    input  logic                    fetch_rdy,
    input  logic [8*WORD_BYTES-1:0] fetch_data,
    output logic                    byte_valid,
    output logic [7:0]              byte_data,
    input  logic                    byte_ready
);

    logic          push;
    logic [CW-1:0] occ;

    pfq_ctrl #(
        .DEPTH    (DEPTH),
        .WB       (WORD_BYTES),
        .LOW_MARK (LOW_MARK)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .data_pending (data_pending),
        .bus_locked   (bus_locked),
        .fetch_rdy    (fetch_rdy),
        .occ          (occ),
        .fetch_req    (fetch_req),
        .push         (push)
    );

    pfq_addr #(
        .AW         (AW),
        .WB         (WORD_BYTES),
        .RESET_ADDR (RESET_ADDR)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_addr (flush_addr),
        .advance    (push),
        .addr       (fetch_addr)
    );

    pfq_store #(
        .DEPTH (DEPTH),
        .WB    (WORD_BYTES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_word (fetch_data),
        .pop_ready (byte_ready),
        .out_valid (byte_valid),
        .out_byte  (byte_data),
        .occ       (occ)
    );

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_rdy && !flush) |=> $stable(fetch_addr));

endmodule

// File: tb/sim_pfq_top.sv
module sim_pfq_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;
    localparam int LOW        = 4;
    localparam int NCYC       = 2500;

    logic        clk = 0;
    logic        rst_n;
    logic        flush;
    logic [31:0] flush_addr;
    logic        data_pending, bus_locked;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_rdy;
    logic [31:0] fetch_data;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ a[23:16];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
    endfunction

    assign fetch_data = mem_word(fetch_addr);

    pfq_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .flush_addr   (flush_addr),
        .data_pending (data_pending),
        .bus_locked   (bus_locked),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_rdy    (fetch_rdy),
        .fetch_data   (fetch_data),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .byte_ready   (byte_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench-side model
    logic [7:0]  exp_q [$];
    logic [31:0] addr_m;
    bit          armed;
    bit          p_flush, p_req, p_rdy, p_pend, p_lock, p_valid, p_ready;
    logic [31:0] p_faddr;
    int          p_cnt;

    initial begin
        bit exp_req, room, low, spur;
        string lab;
        void'($urandom(32'd4242));
        rst_n = 0; flush = 0; flush_addr = 0; data_pending = 0;
        bus_locked = 0; fetch_rdy = 0; byte_ready = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(byte_valid == 0, "R1", "byte_valid in reset", 32'(byte_valid), 0);
        chk(fetch_req == 0,  "R1", "fetch_req in reset", 32'(fetch_req), 0);
        chk(fetch_addr == 0, "R1", "fetch_addr in reset", fetch_addr, 0);
        rst_n  = 1;
        addr_m = 0; armed = 0;
        p_flush = 0; p_req = 0; p_rdy = 0; p_pend = 0; p_lock = 0;
        p_valid = 0; p_ready = 0; p_faddr = 0; p_cnt = 0;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            spur = p_rdy && !p_req && !p_flush;
            // model update for the edge just passed
            if (p_flush) begin
                exp_q.delete();
                addr_m = {p_faddr[31:2], 2'b00};
            end else begin
                if (p_valid && p_ready) void'(exp_q.pop_front());
                if (p_req && p_rdy) begin
                    for (int i = 0; i < 4; i++) exp_q.push_back(mem_byte(addr_m + 32'(i)));
                    addr_m = addr_m + 4;
                end
            end
            room = (p_cnt + 4 <= DEPTH);
            low  = (p_cnt <= LOW);
            if (p_flush)    exp_req = 0;
            else if (p_req) exp_req = !p_rdy;
            else            exp_req = (armed || low) && !p_pend && !p_lock && room;
            if (p_flush) armed = 1;
            else if (p_req) begin
                if (p_rdy) armed = 1;
            end else if (!exp_req) begin
                if (low) armed = 1;
                else if (!room) armed = 0;
            end
            // checks
            if (p_flush) lab = "R9";
            else if (p_req) lab = "R8";
            else if (fetch_req && !exp_req) begin
                if (p_pend) lab = "R6";
                else if (p_lock) lab = "R7";
                else if (!room) lab = "R5";
                else lab = "R4";
            end else lab = "R5";
            chk(fetch_req == exp_req, lab, "fetch_req", 32'(fetch_req), 32'(exp_req));
            if (fetch_req)
                chk(fetch_addr == addr_m, "R2", "fetch_addr", fetch_addr, addr_m);
            if (p_flush)
                chk(byte_valid == 0, "R9", "byte_valid after flush", 32'(byte_valid), 0);
            else if (spur)
                chk(byte_valid == (exp_q.size() != 0), "R10", "byte_valid after stray ready",
                    32'(byte_valid), 32'(exp_q.size() != 0));
            else
                chk(byte_valid == (exp_q.size() != 0), "R3", "byte_valid",
                    32'(byte_valid), 32'(exp_q.size() != 0));
            if (byte_valid && exp_q.size() != 0)
                chk(byte_data == exp_q[0], "R2", "byte_data", 32'(byte_data), 32'(exp_q[0]));
            // directed end-of-phase checks
            if (cyc == 1559)
                chk(!fetch_req && byte_valid, "R5", "fill stops when full",
                    32'({fetch_req, byte_valid}), 32'b01);
            if (cyc == 1790)
                chk(!fetch_req && !byte_valid, "R7", "no fetch while locked",
                    32'({fetch_req, byte_valid}), 0);
            if (cyc == 1890)
                chk(!fetch_req && !byte_valid, "R6", "no fetch while pending",
                    32'({fetch_req, byte_valid}), 0);
            // drive next inputs
            flush = 0;
            fetch_rdy = 0;
            if (cyc < 1500 || cyc >= 1900) begin
                byte_ready   = ($urandom_range(0, 99) < 60);
                data_pending = ($urandom_range(0, 99) < 15);
                bus_locked   = ($urandom_range(0, 99) < 10);
                if (fetch_req) fetch_rdy = ($urandom_range(0, 99) < 50);
                else           fetch_rdy = ($urandom_range(0, 99) < 10);
                flush = ($urandom_range(0, 99) < ((cyc >= 1900) ? 8 : 2));
                flush_addr = $urandom();
            end else if (cyc < 1560) begin
                byte_ready = 0; data_pending = 0; bus_locked = 0;
                fetch_rdy = fetch_req;
                if (cyc == 1500) begin flush = 1; flush_addr = 32'h0000_1003; end
            end else if (cyc < 1700) begin
                byte_ready = ($urandom_range(0, 99) < 30);
                data_pending = 0; bus_locked = 0;
                fetch_rdy = fetch_req;
            end else if (cyc < 1795) begin
                byte_ready = 1; data_pending = 0; bus_locked = 1;
                fetch_rdy = fetch_req;
            end else begin
                byte_ready = 1; data_pending = 1; bus_locked = (cyc < 1800);
                fetch_rdy = fetch_req;
            end
            // snapshot
            p_flush = flush; p_req = fetch_req; p_rdy = fetch_rdy;
            p_pend = data_pending; p_lock = bus_locked;
            p_valid = byte_valid; p_ready = byte_ready;
            p_faddr = flush_addr; p_cnt = exp_q.size();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule